// File: doc/BRIEF.md
# I2C START/STOP Condition Sequencer

This block turns the host's start and stop request flags into bus conditions on an I2C bus: a START when the bus is free, a repeated START in the middle of a master transfer, and a STOP that ends one. It watches START and STOP events reported by a bus-event detector and keeps a bus-busy flag. It also times the bus-free interval that must pass after any STOP before it may begin a new START. A start request made while another master owns the bus, or while this device is an addressed slave, is held until that transfer ends with a STOP and the bus-free interval has run out.

The sequencer drives two open-drain requests, one to pull SDA low and one to pull SCL low. Each condition is a short series of phases, each `PHASE_CYC` system clocks long. A neighbouring byte engine shifts the data and reports each completed byte. It also reports whether this device is still acting as master. The sequencer returns single-cycle strobes: one when a START has been placed, one that clears the stop flag once a STOP is seen on the bus, and one that clears the serial-interrupt flag when the host writes the control register. While the interrupt flag is pending, SCL is held low if it was already low. An SCL that is high is left alone.

States: `SQ_IDLE` (nothing queued), `SQ_WAIT_FREE` (start queued, waiting for the bus to be free), `SQ_ST_HOLD` (SDA low with SCL released), `SQ_ST_LOCK` (both low, START complete), `SQ_MASTER` (byte engine owns the bus), `SQ_RS_LOW`, `SQ_RS_HIGH`, `SQ_RS_SETUP` (the three phases of a repeated START), `SQ_SP_LOW`, `SQ_SP_HIGH` (the STOP phases) and `SQ_SP_DONE` (lines released, waiting for the STOP to be detected).

Transitions:
- `SQ_IDLE` to `SQ_WAIT_FREE`: start request set.
- `SQ_WAIT_FREE` to `SQ_IDLE`: request withdrawn.
- `SQ_WAIT_FREE` to `SQ_ST_HOLD`: bus free.
- `SQ_ST_HOLD` to `SQ_ST_LOCK` to `SQ_MASTER`: each after one phase.
- `SQ_MASTER` to `SQ_IDLE`: master indication low.
- `SQ_MASTER` to `SQ_SP_LOW`: stop request set.
- `SQ_MASTER` to `SQ_RS_LOW`: start request set and a byte already done.
- `SQ_RS_LOW` to `SQ_RS_HIGH` to `SQ_RS_SETUP` to `SQ_ST_LOCK`: each after one phase.
- `SQ_SP_LOW` to `SQ_SP_HIGH` to `SQ_SP_DONE`: each after one phase.
- `SQ_SP_DONE` to `SQ_WAIT_FREE` or `SQ_IDLE`: STOP detected, chosen by whether a start request is still set.

Top module: `i2c_cond_seq`

## Requirements
- R1: After reset both drive requests, all strobes and the bus-busy flag are 0. The bus-free interval counts as already elapsed.
- R2: A detected START sets the bus-busy flag on the next clock. A detected STOP without a START in the same cycle clears it on the next clock.
- R3: When the start request is set and the bus is free, the SDA request rises while the SCL request stays 0 for `PHASE_CYC` cycles. Both requests are then 1 for `PHASE_CYC` cycles, and the start strobe is 1 in the last of those. Both are then released. With the request raised d cycles after a STOP, SDA is pulled at cycle max(d+2, `TBUF_CYC`+2).
- R4: A start request made while the bus is busy does not pull SDA until a STOP is detected. SDA is then pulled exactly `TBUF_CYC`+2 cycles after the cycle in which the STOP detection was presented, and never sooner than `TBUF_CYC` cycles after it.
- R5: A START detected while the bus-free interval is running makes the bus busy again. The queued START then waits for the next STOP, and its interval is counted from that STOP.
- R6: In master state a start request produces nothing until a byte-done pulse has been seen. After that, the lines follow this sequence:
  - SCL low with SDA released for one phase.
  - Both released for one phase.
  - SDA low with SCL released for one phase.
  - Both low for one phase, with the start strobe in its last cycle.
- R7: A stop request in master state drives (SDA low, SCL low) for one phase, then (SDA low, SCL released) for one phase. It then releases both and holds them released until a STOP is detected.
- R8: A STOP detected while the stop request is set produces a one-cycle stop-clear strobe on the next clock.
- R9: Start and stop requests set together in master state produce the STOP sequence first. A START follows `TBUF_CYC`+2 cycles after that STOP is detected.
- R10: With the interrupt flag set, an SCL seen low is held low from the next clock until the flag clears. With SCL high and no condition in progress, the SCL request stays 0.
- R11: A host write to the control register produces a one-cycle interrupt-clear strobe on the next clock.
- R12: When the master indication falls in master state, the sequencer returns to idle. A later stop request then drives nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sta_req | input | 1 | Start request flag from the control register |
| sto_req | input | 1 | Stop request flag from the control register |
| start_det | input | 1 | One-cycle pulse: START seen on the bus |
| stop_det | input | 1 | One-cycle pulse: STOP seen on the bus |
| master_act | input | 1 | Byte engine reports this device is master |
| byte_done | input | 1 | One-cycle pulse: a byte finished in master mode |
| si_flag | input | 1 | Serial-interrupt flag pending |
| scl_in | input | 1 | Sampled SCL line level |
| host_wr | input | 1 | One-cycle pulse: host wrote the control register |
| sda_drive_low | output | 1 | Request to pull SDA low |
| scl_drive_low | output | 1 | Request to pull SCL low |
| start_done | output | 1 | One-cycle strobe: START or repeated START placed |
| sto_clr | output | 1 | One-cycle strobe clearing the stop flag |
| si_clr | output | 1 | One-cycle strobe clearing the interrupt flag |
| bus_busy | output | 1 | Bus currently owned by some master |

## Verification
The start path is swept over every offset of the start request relative to a STOP, from zero up to past the bus-free window. This separates a START that waits for the interval from one that goes out at once on a free bus. A second sweep injects a foreign START at each cycle of the bus-free window, so that restarting the interval is told apart from letting it keep running. Directed sequences cover the following:
- A repeated START requested before and after a byte, which shows that the byte gate matters.
- A lone STOP and a STOP combined with a START.
- SCL stretching with the line low and with it high.
- Loss of the master indication.

// File: rtl/i2c_seq_pkg.sv
package i2c_seq_pkg;

    typedef enum logic [3:0] {
        SQ_IDLE,
        SQ_WAIT_FREE,
        SQ_ST_HOLD,
        SQ_ST_LOCK,
        SQ_MASTER,
        SQ_RS_LOW,
        SQ_RS_HIGH,
        SQ_RS_SETUP,
        SQ_SP_LOW,
        SQ_SP_HIGH,
        SQ_SP_DONE
    } seq_state_e;

    typedef struct packed {
        logic sda_low;
        logic scl_low;
    } line_drv_t;

endpackage

// File: rtl/i2c_seq_busmon.sv
// Bus ownership tracking and bus-free interval timer.
module i2c_seq_busmon #(
    parameter int TBUF_CYC = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_det,
    input  logic stop_det,
    output logic bus_busy,
    output logic bus_free
);
    localparam int CW = $clog2(TBUF_CYC + 1);
    localparam logic [CW-1:0] TB_END = CW'(TBUF_CYC);

    logic [CW-1:0] gap_cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_busy <= 1'b0;
        end else if (start_det) begin
            bus_busy <= 1'b1;
        end else if (stop_det) begin
            bus_busy <= 1'b0;
        end
    end

    // Saturating count of cycles since the last STOP; starts elapsed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap_cnt <= TB_END;
        end else if (stop_det) begin
            gap_cnt <= '0;
        end else if (gap_cnt != TB_END) begin
            gap_cnt <= gap_cnt + 1'b1;
        end
    end

    assign bus_free = !bus_busy && (gap_cnt == TB_END);

endmodule

// File: rtl/i2c_seq_fsm.sv
// Condition sequencing state machine.
module i2c_seq_fsm
    import i2c_seq_pkg::*;
#(
    parameter int PHASE_CYC = 4
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      sta_req,
    input  logic      sto_req,
    input  logic      stop_det,
    input  logic      bus_free,
    input  logic      master_act,
    input  logic      byte_done,
    output line_drv_t drv,
    output logic      start_done
);
    localparam int PW = (PHASE_CYC > 1) ? $clog2(PHASE_CYC) : 1;
    localparam logic [PW-1:0] PH_LAST = PW'(PHASE_CYC - 1);

    seq_state_e state_q, state_nx;
    logic [PW-1:0] ph_cnt;
    logic ph_done;
    logic byte_seen;

    assign ph_done = (ph_cnt == PH_LAST);

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SQ_IDLE;
        end else begin
            state_q <= state_nx;
        end
    end

    // Phase timer restarts on every state change
    always_ff @(posedge clk) begin
        if (!rst_n || (state_nx != state_q)) begin
            ph_cnt <= '0;
        end else begin
            ph_cnt <= ph_cnt + 1'b1;
        end
    end

    // A byte must pass in master state before a repeated START
    always_ff @(posedge clk) begin
        if (!rst_n || (state_q != SQ_MASTER)) begin
            byte_seen <= 1'b0;
        end else if (byte_done) begin
            byte_seen <= 1'b1;
        end
    end

    // Next-state logic
    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            SQ_IDLE: begin
                if (sta_req) state_nx = SQ_WAIT_FREE;
            end
            SQ_WAIT_FREE: begin
                if (!sta_req)     state_nx = SQ_IDLE;
                else if (bus_free) state_nx = SQ_ST_HOLD;
            end
            SQ_ST_HOLD: begin
                if (ph_done) state_nx = SQ_ST_LOCK;
            end
            SQ_ST_LOCK: begin
                if (ph_done) state_nx = SQ_MASTER;
            end
            SQ_MASTER: begin
                if (!master_act)               state_nx = SQ_IDLE;
                else if (sto_req)              state_nx = SQ_SP_LOW;
                else if (sta_req && byte_seen) state_nx = SQ_RS_LOW;
            end
            SQ_RS_LOW: begin
                if (ph_done) state_nx = SQ_RS_HIGH;
            end
            SQ_RS_HIGH: begin
                if (ph_done) state_nx = SQ_RS_SETUP;
            end
            SQ_RS_SETUP: begin
                if (ph_done) state_nx = SQ_ST_LOCK;
            end
            SQ_SP_LOW: begin
                if (ph_done) state_nx = SQ_SP_HIGH;
            end
            SQ_SP_HIGH: begin
                if (ph_done) state_nx = SQ_SP_DONE;
            end
            SQ_SP_DONE: begin
                if (stop_det) state_nx = sta_req ? SQ_WAIT_FREE : SQ_IDLE;
            end
            default: state_nx = SQ_IDLE;
        endcase
    end

    // Output decode
    always_comb begin
        drv        = '0;
        start_done = 1'b0;
        unique case (state_q)
            SQ_ST_HOLD:  drv.sda_low = 1'b1;
            SQ_ST_LOCK: begin
                drv.sda_low = 1'b1;
                drv.scl_low = 1'b1;
                start_done  = ph_done;
            end
            SQ_RS_LOW:   drv.scl_low = 1'b1;
            SQ_RS_SETUP: drv.sda_low = 1'b1;
            SQ_SP_LOW: begin
                drv.sda_low = 1'b1;
                drv.scl_low = 1'b1;
            end
            SQ_SP_HIGH:  drv.sda_low = 1'b1;
            default: begin
                drv        = '0;
                start_done = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/i2c_seq_flags.sv
// Interrupt clock stretch and flag-clear strobes.
module i2c_seq_flags (
    input  logic clk,
    input  logic rst_n,
    input  logic si_flag,
    input  logic scl_in,
    input  logic stop_det,
    input  logic sto_req,
    input  logic host_wr,
    output logic stretch,
    output logic sto_clr,
    output logic si_clr
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stretch <= 1'b0;
            sto_clr <= 1'b0;
            si_clr  <= 1'b0;
        end else begin
            stretch <= si_flag && (stretch || !scl_in);
            sto_clr <= stop_det && sto_req;
            si_clr  <= host_wr;
        end
    end

endmodule

// File: rtl/i2c_cond_seq.sv
module i2c_cond_seq
    import i2c_seq_pkg::*;
#(
    parameter int TBUF_CYC  = 8,
    parameter int PHASE_CYC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sta_req,
    input  logic sto_req,
    input  logic start_det,
    input  logic stop_det,
    input  logic master_act,
    input  logic byte_done,
    input  logic si_flag,
    input  logic scl_in,
    input  logic host_wr,
    output logic sda_drive_low,
    output logic scl_drive_low,
    output logic start_done,
    output logic sto_clr,
    output logic si_clr,
    output logic bus_busy
);
    line_drv_t seq_drv;
    logic      bus_free;
    logic      stretch;

    i2c_seq_busmon #(.TBUF_CYC(TBUF_CYC)) u_busmon (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_det (start_det),
        .stop_det  (stop_det),
        .bus_busy  (bus_busy),
        .bus_free  (bus_free)
    );

    i2c_seq_fsm #(.PHASE_CYC(PHASE_CYC)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .sta_req    (sta_req),
        .sto_req    (sto_req),
        .stop_det   (stop_det),
        .bus_free   (bus_free),
        .master_act (master_act),
        .byte_done  (byte_done),
        .drv        (seq_drv),
        .start_done (start_done)
    );

    i2c_seq_flags u_flags (
        .clk      (clk),
        .rst_n    (rst_n),
        .si_flag  (si_flag),
        .scl_in   (scl_in),
        .stop_det (stop_det),
        .sto_req  (sto_req),
        .host_wr  (host_wr),
        .stretch  (stretch),
        .sto_clr  (sto_clr),
        .si_clr   (si_clr)
    );

    assign sda_drive_low = seq_drv.sda_low;
    assign scl_drive_low = seq_drv.scl_low | stretch;

endmodule

// File: rtl/i2c_cond_seq_chk.sv
module i2c_cond_seq_chk #(
    parameter int TBUF_CYC = 8
) (
    input logic clk,
    input logic rst_n,
    input logic start_det,
    input logic stop_det,
    input logic sto_req,
    input logic host_wr,
    input logic si_flag,
    input logic scl_in,
    input logic master_act,
    input logic sda_drive_low,
    input logic scl_drive_low,
    input logic start_done,
    input logic sto_clr,
    input logic si_clr,
    input logic bus_busy
);
    // Independent count of cycles since the last STOP detection
    logic [15:0] since_stop;
    always_ff @(posedge clk) begin
        if (!rst_n)                 since_stop <= 16'hFFFF;
        else if (stop_det)          since_stop <= 16'd0;
        else if (since_stop != 16'hFFFF) since_stop <= since_stop + 16'd1;
    end

    a_r2_busy_set: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> bus_busy);

    a_r2_busy_clr: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_det && !start_det) |=> !bus_busy);

    a_r3_start_lock: assert property (@(posedge clk) disable iff (!rst_n)
        start_done |-> (sda_drive_low && scl_drive_low));

    a_r4_tbuf_kept: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(sda_drive_low) && !scl_drive_low && !master_act)
            |-> (since_stop >= 16'(TBUF_CYC)));

    a_r8_sto_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_det && sto_req) |=> sto_clr);

    a_r10_stretch_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (si_flag && !scl_in) |=> scl_drive_low);

    a_r11_si_clear: assert property (@(posedge clk) disable iff (!rst_n)
        host_wr |=> si_clr);

endmodule

bind i2c_cond_seq i2c_cond_seq_chk #(.TBUF_CYC(TBUF_CYC)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .start_det     (start_det),
    .stop_det      (stop_det),
    .sto_req       (sto_req),
    .host_wr       (host_wr),
    .si_flag       (si_flag),
    .scl_in        (scl_in),
    .master_act    (master_act),
    .sda_drive_low (sda_drive_low),
    .scl_drive_low (scl_drive_low),
    .start_done    (start_done),
    .sto_clr       (sto_clr),
    .si_clr        (si_clr),
    .bus_busy      (bus_busy)
);

// File: tb/i2c_cond_seq_tb.sv
module i2c_cond_seq_tb;
    localparam int T = 8;
    localparam int P = 4;

    logic clk = 1'b0;
    logic rst_n, sta_req, sto_req, start_det, stop_det, master_act;
    logic byte_done, si_flag, scl_in, host_wr;
    logic sda_drive_low, scl_drive_low, start_done, sto_clr, si_clr, bus_busy;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    i2c_cond_seq #(.TBUF_CYC(T), .PHASE_CYC(P)) u_dut (
        .clk(clk), .rst_n(rst_n), .sta_req(sta_req), .sto_req(sto_req),
        .start_det(start_det), .stop_det(stop_det), .master_act(master_act),
        .byte_done(byte_done), .si_flag(si_flag), .scl_in(scl_in),
        .host_wr(host_wr), .sda_drive_low(sda_drive_low),
        .scl_drive_low(scl_drive_low), .start_done(start_done),
        .sto_clr(sto_clr), .si_clr(si_clr), .bus_busy(bus_busy)
    );

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic chk_lines(input string tag, input bit sda, input bit scl, input bit sd);
        chk({tag, " sda"}, int'(sda_drive_low), int'(sda));
        chk({tag, " scl"}, int'(scl_drive_low), int'(scl));
        chk({tag, " start_done"}, int'(start_done), int'(sd));
    endtask

    task automatic do_reset();
        rst_n = 1'b0; sta_req = 0; sto_req = 0; start_det = 0; stop_det = 0;
        master_act = 0; byte_done = 0; si_flag = 0; scl_in = 1; host_wr = 0;
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
    endtask

    task automatic pulse_start_det();
        start_det = 1'b1; tick(); start_det = 1'b0;
    endtask

    // Counts negedges after the current one until SDA is pulled
    task automatic count_to_sda(output int n);
        n = 0;
        for (int k = 1; k < 100; k++) begin
            tick();
            stop_det = 1'b0;
            if (sda_drive_low) begin n = k; break; end
        end
    endtask

    // Check START waveform from the first cycle SDA is pulled
    task automatic check_start_shape(input string tag);
        for (int j = 0; j <= 2 * P; j++) begin
            chk_lines(tag, (j < 2 * P), (j >= P && j < 2 * P), (j == 2 * P - 1));
            if (j == 2 * P - 1) sta_req = 1'b0;
            tick();
        end
    endtask

    task automatic go_master();
        do_reset();
        master_act = 1'b1;
        sta_req = 1'b1;
        for (int k = 0; k < 50; k++) begin
            tick();
            if (start_done) break;
        end
        chk("R3 start_done reached", int'(start_done), 1);
        sta_req = 1'b0;
        start_det = 1'b1;
        tick();
        start_det = 1'b0;
        tick();
    endtask

    initial begin
        int n, exp;
        do_reset();
        // R1 reset state
        chk_lines("R1 reset", 0, 0, 0);
        chk("R1 busy", int'(bus_busy), 0);
        chk("R1 sto_clr", int'(sto_clr), 0);
        chk("R1 si_clr", int'(si_clr), 0);

        // R2 busy tracking
        pulse_start_det(); chk("R2 busy after start", int'(bus_busy), 1);
        stop_det = 1'b1; tick(); stop_det = 1'b0;
        chk("R2 busy after stop", int'(bus_busy), 0);

        // R3/R4 sweep: start request d cycles after a STOP
        for (int d = 0; d <= T + 3; d++) begin
            do_reset();
            pulse_start_det();
            tick();
            chk("R4 held while busy", int'(sda_drive_low), 0);
            stop_det = 1'b1;
            if (d == 0) sta_req = 1'b1;
            n = 0;
            for (int k = 1; k < 100; k++) begin
                tick();
                stop_det = 1'b0;
                if (sda_drive_low) begin n = k; break; end
                if (k == d) sta_req = 1'b1;
            end
            exp = (d + 2 > T + 2) ? d + 2 : T + 2;
            chk($sformatf("R4 R3 start delay d=%0d", d), n, exp);
            check_start_shape("R3 shape");
        end

        // R4 request queued before the STOP, bus busy a long time
        do_reset();
        pulse_start_det();
        sta_req = 1'b1;
        repeat (3 * T) tick();
        chk("R4 no start while busy", int'(sda_drive_low), 0);
        stop_det = 1'b1;
        count_to_sda(n);
        chk("R4 queued start delay", n, T + 2);

        // R5 foreign START at each cycle of the bus-free window
        for (int f = 1; f <= T; f++) begin
            do_reset();
            pulse_start_det();
            sta_req = 1'b1;
            stop_det = 1'b1;
            for (int k = 1; k <= f + 2; k++) begin
                tick();
                stop_det = 1'b0;
                start_det = (k == f);
                chk("R5 no early start", int'(sda_drive_low), 0);
            end
            start_det = 1'b0;
            chk("R5 busy again", int'(bus_busy), 1);
            stop_det = 1'b1;
            count_to_sda(n);
            chk($sformatf("R5 restart f=%0d", f), n, T + 2);
        end

        // R6 repeated START gated by a byte
        go_master();
        chk_lines("R6 master idle lines", 0, 0, 0);
        sta_req = 1'b1;
        repeat (4) begin
            tick();
            chk_lines("R6 no byte yet", 0, 0, 0);
        end
        byte_done = 1'b1; tick(); byte_done = 1'b0; tick();
        for (int j = 0; j <= 4 * P; j++) begin
            chk_lines("R6 rs shape", (j >= 2 * P && j < 4 * P),
                      (j < P) || (j >= 3 * P && j < 4 * P), (j == 4 * P - 1));
            if (j == 4 * P - 1) sta_req = 1'b0;
            tick();
        end

        // R7/R8 STOP
        sto_req = 1'b1;
        tick();
        for (int j = 0; j < 2 * P + 4; j++) begin
            chk_lines("R7 stop shape", (j < 2 * P), (j < P), 0);
            tick();
        end
        chk("R8 no clear before stop", int'(sto_clr), 0);
        stop_det = 1'b1; tick(); stop_det = 1'b0; sto_req = 1'b0;
        chk("R8 sto_clr", int'(sto_clr), 1);
        tick();
        chk("R8 sto_clr single", int'(sto_clr), 0);
        chk_lines("R7 after stop", 0, 0, 0);

        // R9 combined STOP then START
        go_master();
        sta_req = 1'b1; sto_req = 1'b1;
        tick();
        chk_lines("R9 stop first", 1, 1, 0);
        repeat (2 * P + 2) tick();
        chk_lines("R9 released", 0, 0, 0);
        stop_det = 1'b1;
        n = 0;
        for (int k = 1; k < 100; k++) begin
            tick();
            stop_det = 1'b0; sto_req = 1'b0;
            if (sda_drive_low) begin n = k; break; end
        end
        chk("R9 start after tbuf", n, T + 2);
        chk("R9 is a start", int'(scl_drive_low), 0);
        check_start_shape("R9 shape");

        // R12 master loss
        go_master();
        master_act = 1'b0;
        tick();
        sto_req = 1'b1;
        repeat (4) begin
            tick();
            chk_lines("R12 no stop after loss", 0, 0, 0);
        end
        sto_req = 1'b0;

        // R10 stretch, R11 interrupt clear
        do_reset();
        si_flag = 1'b1;
        repeat (3) tick();
        chk("R10 high scl untouched", int'(scl_drive_low), 0);
        scl_in = 1'b0; tick();
        chk("R10 held low", int'(scl_drive_low), 1);
        scl_in = 1'b1; tick();
        chk("R10 still held", int'(scl_drive_low), 1);
        si_flag = 1'b0; tick();
        chk("R10 released", int'(scl_drive_low), 0);
        host_wr = 1'b1; tick(); host_wr = 1'b0;
        chk("R11 si_clr", int'(si_clr), 1);
        tick();
        chk("R11 si_clr single", int'(si_clr), 0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got 0 expected 1");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule